// File: doc/BRIEF.md
# Ethernet MAC Control and Status Register Bank

This block holds the software-visible configuration and status of an Ethernet MAC behind a simple single-cycle 32-bit request bus. A request carries a word offset, a size code, a write flag and write data. A read returns registered data one cycle later. A request that is malformed or that hits no register raises a one-cycle error pulse instead.

Each register follows its own write rule. Most are plain read/write. Some clear bits when written with ones, either over a fixed mask or over the full word. The live RX and TX status words ignore writes. The datapath sets status, sticky and event bits through set inputs, and these win over a clear in the same cycle. A bank of RX and TX statistics counters sits in its own address windows. Its control word has a self-clearing bit that zeroes every counter at once. The receive and transmit enables and a counter-clear strobe are driven back to the datapath.

Offsets used below: 0 mode, 1 station address low, 2 station address high, 3/4 hash filter, 5/6 management address/data, 7 flow control, 8/9 VLAN tags, 11 wake control, 12–19 wake filter words, 24 system control, 25 system status, 26 RX status, 27 RX sticky, 28 RX interrupt enable, 29 TX status, 30 TX sticky, 31 TX interrupt enable, 32 counter control, 33 RX counter event, 34 RX counter event enable, 35 TX counter event, 36 TX counter event enable, 40–63 timestamp window, 64+i RX counter i, 96+i TX counter i.

Top module: `emac_csr_top`

## Requirements
- R1: Only size code 2'b10 (32-bit) is accepted; any other size gives bus_err in the next cycle and has no effect, whatever the offset.
- R2: Offsets outside every defined window (10, 20–23, 37–39, 64+NRX–95, 96+NTX and above) give bus_err in the next cycle, no rd_valid and no write effect.
- R3: After reset: station address low 0xFFFFFFFF, station address high 0x0000FFFF, both VLAN tags 0x0000FFFF, system control 0x00003F00, counter control 0x0000000A, every other register 0, and all outputs low.
- R4: Offsets 1–9, 12–19, 24, 28, 31, 34 and 36 store the full written word and read it back.
- R5: A write that takes mode bit 0 from 0 to 1 clears RX status bit 0, and one that takes mode bit 1 from 0 to 1 clears TX status bit 0; rx_en and tx_en follow mode bits 0 and 1.
- R6: Wake control: bits in mask 0xF20 clear where written with 1, bits outside the mask take the written value, and wake_set sets only masked bits.
- R7: System status: a write clears only the written-1 bits within mask 0xE1; sys_stat_set sets any bit.
- R8: RX sticky, TX sticky and both counter-event registers clear on all 32 bits where written with 1.
- R9: Writes to RX and TX status are discarded; rx_stat_set and tx_stat_set OR into the status word and into the matching sticky word.
- R10: Writing counter control with bit 0 set zeroes every counter, pulses stats_clr in the following cycle, and bit 0 always reads 0; the other bits are plain storage.
- R11: The timestamp window 40–63 accepts writes with no effect and reads back 0 with rd_valid and no error.
- R12: rd_valid and rd_data appear exactly one cycle after a read request and last one cycle.
- R13: When a set input and a write-one-to-clear hit the same bit in the same cycle, the bit ends set.
- R14: A counter increments on its inc bit, is readable and writable at its offset, and on wrapping from all ones to 0 sets its bit in the counter event register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Word offset |
| req_size | input | 2 | Size code, 2'b10 = 32-bit |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| bus_err | output | 1 | Access error pulse |
| rx_stat_set | input | 32 | Set bits for RX status and sticky |
| tx_stat_set | input | 32 | Set bits for TX status and sticky |
| sys_stat_set | input | 32 | Set bits for system status |
| wake_set | input | 32 | Set bits for wake control (masked) |
| rx_cnt_inc | input | NRX | RX counter increments |
| tx_cnt_inc | input | NTX | TX counter increments |
| rx_en | output | 1 | Receive enable |
| tx_en | output | 1 | Transmit enable |
| stats_clr | output | 1 | Counter clear strobe |

## Verification
Every cycle the assertions check the error pulse for bad sizes and unmapped offsets, the one-cycle read latency, the clearing of the RX completion bit on a rising receive enable, that RX status ignores writes, that set inputs beat a same-cycle clear, and the counter clear and wrap behaviour. The mask-specific clearing of wake control and system status, the reset values, the readback of each register, the silent timestamp window and the counter event bits are shown only by the bench's scenarios, which read the values back through the bus.

// File: rtl/emac_csr_pkg.sv
package emac_csr_pkg;

    typedef logic [31:0] word_t;

    localparam logic [1:0] SZ_WORD = 2'b10;

    // word offsets
    localparam int A_MODE    = 0;
    localparam int A_ADRL    = 1;
    localparam int A_ADRH    = 2;
    localparam int A_HASHL   = 3;
    localparam int A_HASHH   = 4;
    localparam int A_MGA     = 5;
    localparam int A_MGD     = 6;
    localparam int A_FLOW    = 7;
    localparam int A_VLAN1   = 8;
    localparam int A_VLAN2   = 9;
    localparam int A_WAKE    = 11;
    localparam int A_WFLT    = 12;
    localparam int N_WFLT    = 8;
    localparam int A_SYSCTL  = 24;
    localparam int A_SYSST   = 25;
    localparam int A_RXST    = 26;
    localparam int A_RXSK    = 27;
    localparam int A_RXIE    = 28;
    localparam int A_TXST    = 29;
    localparam int A_TXSK    = 30;
    localparam int A_TXIE    = 31;
    localparam int A_CCTL    = 32;
    localparam int A_CEV_RX  = 33;
    localparam int A_CEN_RX  = 34;
    localparam int A_CEV_TX  = 35;
    localparam int A_CEN_TX  = 36;
    localparam int A_TS_LO   = 40;
    localparam int A_TS_HI   = 63;
    localparam int A_RXC     = 64;
    localparam int A_TXC     = 96;
    localparam int CNT_SPAN  = 32;

    localparam word_t WAKE_W1C = 32'h0000_0F20;
    localparam word_t SYST_W1C = 32'h0000_00E1;

    localparam int RE_BIT   = 0;
    localparam int TE_BIT   = 1;
    localparam int COMP_BIT = 0;
    localparam int CLR_BIT  = 0;

    typedef enum logic [2:0] {K_BAD, K_REG, K_SILENT, K_RXC, K_TXC} kind_t;

    typedef struct packed {
        word_t                    mode;
        word_t                    adr_lo;
        word_t                    adr_hi;
        word_t                    hash_lo;
        word_t                    hash_hi;
        word_t                    mg_adr;
        word_t                    mg_dat;
        word_t                    flow;
        word_t                    vlan1;
        word_t                    vlan2;
        word_t                    wake;
        logic [N_WFLT-1:0][31:0]  wflt;
        word_t                    sysctl;
        word_t                    sysst;
        word_t                    rx_st;
        word_t                    rx_sk;
        word_t                    rx_ie;
        word_t                    tx_st;
        word_t                    tx_sk;
        word_t                    tx_ie;
        word_t                    c_ctl;
        word_t                    cev_rx;
        word_t                    cen_rx;
        word_t                    cev_tx;
        word_t                    cen_tx;
    } regs_t;

endpackage

// File: rtl/emac_csr_decode.sv
module emac_csr_decode
    import emac_csr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NRX    = 4,
    parameter int NTX    = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output kind_t             kind
);

    logic [31:0] a;
    assign a = 32'(addr);

    always_comb begin
        kind = K_BAD;
        if (size == SZ_WORD) begin
            if (a <= 32'(A_VLAN2))
                kind = K_REG;
            else if (a >= 32'(A_WAKE) && a < 32'(A_WFLT + N_WFLT))
                kind = K_REG;
            else if (a >= 32'(A_SYSCTL) && a <= 32'(A_CEN_TX))
                kind = K_REG;
            else if (a >= 32'(A_TS_LO) && a <= 32'(A_TS_HI))
                kind = K_SILENT;
            else if (a >= 32'(A_RXC) && a < 32'(A_RXC + NRX))
                kind = K_RXC;
            else if (a >= 32'(A_TXC) && a < 32'(A_TXC + NTX))
                kind = K_TXC;
        end
    end

endmodule

// File: rtl/emac_stat_cnt.sv
module emac_stat_cnt #(
    parameter int N = 4,
    parameter int W = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [W-1:0]        wr_data,
    input  logic [N-1:0]        inc,
    output logic [N-1:0][W-1:0] cnt,
    output logic [N-1:0]        wrap
);

    logic [N-1:0][W-1:0] cnt_d, cnt_q;

    for (genvar g = 0; g < N; g++) begin : g_cnt
        logic hit;
        assign hit      = wr_en && (wr_idx == IDX_W'(g));
        assign cnt_d[g] = clr    ? '0 :
                          hit    ? wr_data :
                          inc[g] ? cnt_q[g] + W'(1) : cnt_q[g];
        assign wrap[g]  = inc[g] && !clr && !hit && (&cnt_q[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R10
    cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    // R14
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc[0] && !clr && !wr_en && (&cnt_q[0])) |=> (cnt_q[0] == '0));

endmodule

// File: rtl/emac_csr_top.sv
module emac_csr_top
    import emac_csr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NRX    = 4,
    parameter int NTX    = 4,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              bus_err,
    input  logic [31:0]       rx_stat_set,
    input  logic [31:0]       tx_stat_set,
    input  logic [31:0]       sys_stat_set,
    input  logic [31:0]       wake_set,
    input  logic [NRX-1:0]    rx_cnt_inc,
    input  logic [NTX-1:0]    tx_cnt_inc,
    output logic              rx_en,
    output logic              tx_en,
    output logic              stats_clr
);

    localparam int RX_IW = (NRX > 1) ? $clog2(NRX) : 1;
    localparam int TX_IW = (NTX > 1) ? $clog2(NTX) : 1;

    typedef struct packed {
        regs_t r;
        word_t rdata;
        logic  rvalid;
        logic  err;
        logic  clr;
    } state_t;

    state_t s_d, s_q;
    kind_t  kind;
    logic [31:0] a32;
    logic [31:0] wi;
    logic        clr_now, rxc_we, txc_we;
    logic [NRX-1:0][CNT_W-1:0] rx_cnt;
    logic [NTX-1:0][CNT_W-1:0] tx_cnt;
    logic [NRX-1:0] rx_wrap;
    logic [NTX-1:0] tx_wrap;

    assign a32 = 32'(req_addr);
    assign wi  = a32 - 32'(A_WFLT);

    emac_csr_decode #(.ADDR_W(ADDR_W), .NRX(NRX), .NTX(NTX)) i_dec (
        .addr (req_addr),
        .size (req_size),
        .kind (kind)
    );

    emac_stat_cnt #(.N(NRX), .W(CNT_W)) i_rxc (
        .clk (clk), .rst_n (rst_n), .clr (clr_now), .wr_en (rxc_we),
        .wr_idx (req_addr[RX_IW-1:0]), .wr_data (req_wdata[CNT_W-1:0]),
        .inc (rx_cnt_inc), .cnt (rx_cnt), .wrap (rx_wrap)
    );

    emac_stat_cnt #(.N(NTX), .W(CNT_W)) i_txc (
        .clk (clk), .rst_n (rst_n), .clr (clr_now), .wr_en (txc_we),
        .wr_idx (req_addr[TX_IW-1:0]), .wr_data (req_wdata[CNT_W-1:0]),
        .inc (tx_cnt_inc), .cnt (tx_cnt), .wrap (tx_wrap)
    );

    function automatic word_t reg_rd(regs_t r, logic [31:0] a, logic [31:0] w);
        word_t v;
        case (a)
            A_MODE:   v = r.mode;
            A_ADRL:   v = r.adr_lo;
            A_ADRH:   v = r.adr_hi;
            A_HASHL:  v = r.hash_lo;
            A_HASHH:  v = r.hash_hi;
            A_MGA:    v = r.mg_adr;
            A_MGD:    v = r.mg_dat;
            A_FLOW:   v = r.flow;
            A_VLAN1:  v = r.vlan1;
            A_VLAN2:  v = r.vlan2;
            A_WAKE:   v = r.wake;
            A_SYSCTL: v = r.sysctl;
            A_SYSST:  v = r.sysst;
            A_RXST:   v = r.rx_st;
            A_RXSK:   v = r.rx_sk;
            A_RXIE:   v = r.rx_ie;
            A_TXST:   v = r.tx_st;
            A_TXSK:   v = r.tx_sk;
            A_TXIE:   v = r.tx_ie;
            A_CCTL:   v = r.c_ctl;
            A_CEV_RX: v = r.cev_rx;
            A_CEN_RX: v = r.cen_rx;
            A_CEV_TX: v = r.cev_tx;
            A_CEN_TX: v = r.cen_tx;
            default:  v = (w < 32'(N_WFLT)) ? r.wflt[w[2:0]] : '0;
        endcase
        return v;
    endfunction

    function automatic state_t rst_state();
        state_t s;
        s          = '0;
        s.r.adr_lo = 32'hFFFF_FFFF;
        s.r.adr_hi = 32'h0000_FFFF;
        s.r.vlan1  = 32'h0000_FFFF;
        s.r.vlan2  = 32'h0000_FFFF;
        s.r.sysctl = 32'h0000_3F00;
        s.r.c_ctl  = 32'h0000_000A;
        return s;
    endfunction

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;
        s_d.err    = 1'b0;
        s_d.rdata  = '0;
        clr_now    = 1'b0;
        rxc_we     = 1'b0;
        txc_we     = 1'b0;
        if (req_valid) begin
            if (kind == K_BAD) begin
                s_d.err = 1'b1;
            end else if (!req_write) begin
                s_d.rvalid = 1'b1;
                case (kind)
                    K_REG:   s_d.rdata = reg_rd(s_q.r, a32, wi);
                    K_RXC:   s_d.rdata = 32'(rx_cnt[req_addr[RX_IW-1:0]]);
                    K_TXC:   s_d.rdata = 32'(tx_cnt[req_addr[TX_IW-1:0]]);
                    default: s_d.rdata = '0;
                endcase
            end else if (kind == K_RXC) begin
                rxc_we = 1'b1;
            end else if (kind == K_TXC) begin
                txc_we = 1'b1;
            end else if (kind == K_REG) begin
                case (a32)
                    A_MODE: begin
                        if (req_wdata[RE_BIT] && !s_q.r.mode[RE_BIT]) s_d.r.rx_st[COMP_BIT] = 1'b0;
                        if (req_wdata[TE_BIT] && !s_q.r.mode[TE_BIT]) s_d.r.tx_st[COMP_BIT] = 1'b0;
                        s_d.r.mode = req_wdata;
                    end
                    A_ADRL:   s_d.r.adr_lo  = req_wdata;
                    A_ADRH:   s_d.r.adr_hi  = req_wdata;
                    A_HASHL:  s_d.r.hash_lo = req_wdata;
                    A_HASHH:  s_d.r.hash_hi = req_wdata;
                    A_MGA:    s_d.r.mg_adr  = req_wdata;
                    A_MGD:    s_d.r.mg_dat  = req_wdata;
                    A_FLOW:   s_d.r.flow    = req_wdata;
                    A_VLAN1:  s_d.r.vlan1   = req_wdata;
                    A_VLAN2:  s_d.r.vlan2   = req_wdata;
                    A_WAKE:   s_d.r.wake    = (req_wdata & ~WAKE_W1C) |
                                              (s_q.r.wake & WAKE_W1C & ~req_wdata);
                    A_SYSCTL: s_d.r.sysctl  = req_wdata;
                    A_SYSST:  s_d.r.sysst   = s_q.r.sysst & ~(req_wdata & SYST_W1C);
                    A_RXST, A_TXST: ;
                    A_RXSK:   s_d.r.rx_sk   = s_q.r.rx_sk & ~req_wdata;
                    A_RXIE:   s_d.r.rx_ie   = req_wdata;
                    A_TXSK:   s_d.r.tx_sk   = s_q.r.tx_sk & ~req_wdata;
                    A_TXIE:   s_d.r.tx_ie   = req_wdata;
                    A_CCTL: begin
                        s_d.r.c_ctl = req_wdata & ~(32'd1 << CLR_BIT);
                        clr_now     = req_wdata[CLR_BIT];
                    end
                    A_CEV_RX: s_d.r.cev_rx  = s_q.r.cev_rx & ~req_wdata;
                    A_CEN_RX: s_d.r.cen_rx  = req_wdata;
                    A_CEV_TX: s_d.r.cev_tx  = s_q.r.cev_tx & ~req_wdata;
                    A_CEN_TX: s_d.r.cen_tx  = req_wdata;
                    default:  if (wi < 32'(N_WFLT)) s_d.r.wflt[wi[2:0]] = req_wdata;
                endcase
            end
        end
        // datapath sets are applied last so they win over clears
        s_d.r.rx_st  = s_d.r.rx_st  | rx_stat_set;
        s_d.r.rx_sk  = s_d.r.rx_sk  | rx_stat_set;
        s_d.r.tx_st  = s_d.r.tx_st  | tx_stat_set;
        s_d.r.tx_sk  = s_d.r.tx_sk  | tx_stat_set;
        s_d.r.sysst  = s_d.r.sysst  | sys_stat_set;
        s_d.r.wake   = s_d.r.wake   | (wake_set & WAKE_W1C);
        s_d.r.cev_rx = s_d.r.cev_rx | 32'(rx_wrap);
        s_d.r.cev_tx = s_d.r.cev_tx | 32'(tx_wrap);
        s_d.clr      = clr_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= rst_state();
        else        s_q <= s_d;
    end

    assign rd_valid  = s_q.rvalid;
    assign rd_data   = s_q.rdata;
    assign bus_err   = s_q.err;
    assign stats_clr = s_q.clr;
    assign rx_en     = s_q.r.mode[RE_BIT];
    assign tx_en     = s_q.r.mode[TE_BIT];

    logic wr_reg;
    assign wr_reg = req_valid && req_write && (kind == K_REG);

    // R1
    size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != SZ_WORD) |=> bus_err);

    // R2
    bad_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == K_BAD) |=> (bus_err && !rd_valid));

    // R12
    rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && kind != K_BAD) |=> (rd_valid && !bus_err));

    // R5
    rx_comp_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_reg && a32 == 32'(A_MODE) && req_wdata[RE_BIT] && !rx_en && !rx_stat_set[COMP_BIT])
        |=> !s_q.r.rx_st[COMP_BIT]);

    // R9
    ro_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_reg && a32 == 32'(A_RXST) && rx_stat_set == '0) |=> $stable(s_q.r.rx_st));

    // R13
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stat_set != '0) |=> ((s_q.r.rx_sk & $past(rx_stat_set)) == $past(rx_stat_set)));

endmodule

// File: tb/test_emac_csr_top.sv
module test_emac_csr_top;
    localparam int NRX = 4;
    localparam int NTX = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = 2'b10;
    logic [31:0] req_wdata = '0;
    logic rd_valid, bus_err, rx_en, tx_en, stats_clr;
    logic [31:0] rd_data;
    logic [31:0] rx_stat_set = '0, tx_stat_set = '0, sys_stat_set = '0, wake_set = '0;
    logic [NRX-1:0] rx_cnt_inc = '0;
    logic [NTX-1:0] tx_cnt_inc = '0;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    emac_csr_top #(.ADDR_W(8), .NRX(NRX), .NTX(NTX), .CNT_W(32)) i_emac_csr_top (
        .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_size, .req_wdata,
        .rd_valid, .rd_data, .bus_err, .rx_stat_set, .tx_stat_set, .sys_stat_set,
        .wake_set, .rx_cnt_inc, .tx_cnt_inc, .rx_en, .tx_en, .stats_clr
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    typedef struct packed {
        logic        wr;
        logic [7:0]  a;
        logic [31:0] d;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 8'd1,  32'h0,        32'hFFFF_FFFF}, // R3
        '{1'b0, 8'd2,  32'h0,        32'h0000_FFFF}, // R3
        '{1'b0, 8'd8,  32'h0,        32'h0000_FFFF}, // R3
        '{1'b0, 8'd9,  32'h0,        32'h0000_FFFF}, // R3
        '{1'b0, 8'd24, 32'h0,        32'h0000_3F00}, // R3
        '{1'b0, 8'd32, 32'h0,        32'h0000_000A}, // R3
        '{1'b0, 8'd0,  32'h0,        32'h0},         // R3
        '{1'b1, 8'd3,  32'h1234_5678, 32'h0},        // R4
        '{1'b0, 8'd3,  32'h0,        32'h1234_5678}, // R4
        '{1'b1, 8'd6,  32'hCAFE_F00D, 32'h0},        // R4
        '{1'b0, 8'd6,  32'h0,        32'hCAFE_F00D}, // R4
        '{1'b1, 8'd15, 32'hA5A5_A5A5, 32'h0},        // R4
        '{1'b0, 8'd15, 32'h0,        32'hA5A5_A5A5}, // R4
        '{1'b1, 8'd28, 32'h0F0F_0F0F, 32'h0},        // R4
        '{1'b0, 8'd28, 32'h0,        32'h0F0F_0F0F}, // R4
        '{1'b1, 8'd26, 32'hFFFF_FFFF, 32'h0},        // R9
        '{1'b0, 8'd26, 32'h0,        32'h0},         // R9
        '{1'b1, 8'd32, 32'h0000_000F, 32'h0},        // R10
        '{1'b0, 8'd32, 32'h0,        32'h0000_000E}, // R10
        '{1'b1, 8'd11, 32'hFFFF_FFFF, 32'h0},        // R6
        '{1'b0, 8'd11, 32'h0,        32'hFFFF_F0DF}, // R6
        '{1'b1, 8'd11, 32'h0,        32'h0}          // R6
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", rq, act, exp);
        end
    endtask

    task automatic op(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [1:0] sz, output logic [31:0] rd,
                      output logic v, output logic e);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_size = sz;
        @(negedge clk);
        rd = rd_data; v = rd_valid; e = bus_err;
        req_valid = 1'b0; req_write = 1'b0; req_size = 2'b10;
    endtask

    task automatic wr32(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] rd; logic v, e;
        op(1'b1, a, d, 2'b10, rd, v, e);
    endtask

    task automatic rd_chk(input string rq, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] rd; logic v, e;
        op(1'b0, a, 32'h0, 2'b10, rd, v, e);
        chk(rq, rd, exp);
    endtask

    task automatic pulse_sets(input logic [31:0] rx, input logic [31:0] tx,
                              input logic [31:0] sy, input logic [31:0] wk);
        @(negedge clk);
        rx_stat_set = rx; tx_stat_set = tx; sys_stat_set = sy; wake_set = wk;
        @(negedge clk);
        rx_stat_set = '0; tx_stat_set = '0; sys_stat_set = '0; wake_set = '0;
    endtask

    task automatic pulse_inc(input logic [NRX-1:0] r, input logic [NTX-1:0] t);
        @(negedge clk);
        rx_cnt_inc = r; tx_cnt_inc = t;
        @(negedge clk);
        rx_cnt_inc = '0; tx_cnt_inc = '0;
    endtask

    initial begin
        logic [31:0] rd; logic v, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 outputs after reset
        chk("R3 rd_valid", 32'(rd_valid), 32'd0);
        chk("R3 bus_err", 32'(bus_err), 32'd0);
        chk("R3 rx_en/tx_en", {30'd0, rx_en, tx_en}, 32'd0);
        chk("R3 stats_clr", 32'(stats_clr), 32'd0);

        for (int i = 0; i < NV; i++) begin
            op(VECS[i].wr, VECS[i].a, VECS[i].d, 2'b10, rd, v, e);
            if (!VECS[i].wr) chk($sformatf("vector %0d", i), rd, VECS[i].exp);
        end

        // R6 wake control
        pulse_sets('0, '0, '0, 32'hFFFF_FFFF);
        rd_chk("R6 masked set", 8'd11, 32'h0000_0F20);
        wr32(8'd11, 32'h0000_0020);
        rd_chk("R6 masked clear", 8'd11, 32'h0000_0F00);

        // R7 system status
        pulse_sets('0, '0, 32'h0000_00FF, '0);
        rd_chk("R7 set", 8'd25, 32'h0000_00FF);
        wr32(8'd25, 32'hFFFF_FFFF);
        rd_chk("R7 masked clear", 8'd25, 32'h0000_001E);

        // R9 / R8 status and sticky
        pulse_sets(32'h81, 32'h5, '0, '0);
        rd_chk("R9 rx status set", 8'd26, 32'h81);
        rd_chk("R9 rx sticky set", 8'd27, 32'h81);
        wr32(8'd27, 32'h1);
        rd_chk("R8 rx sticky w1c", 8'd27, 32'h80);
        wr32(8'd30, 32'h4);
        rd_chk("R8 tx sticky w1c", 8'd30, 32'h1);

        // R5 enables
        wr32(8'd0, 32'h2);
        chk("R5 tx_en", {30'd0, rx_en, tx_en}, 32'h1);
        rd_chk("R5 tx comp cleared", 8'd29, 32'h4);
        wr32(8'd0, 32'h3);
        chk("R5 rx_en", {30'd0, rx_en, tx_en}, 32'h3);
        rd_chk("R5 rx comp cleared", 8'd26, 32'h80);
        pulse_sets(32'h1, '0, '0, '0);
        wr32(8'd0, 32'h3);
        rd_chk("R5 no rise keeps comp", 8'd26, 32'h81);
        wr32(8'd0, 32'h0);

        // R13 set beats clear
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'd27; req_wdata = 32'h2;
        rx_stat_set = 32'h2;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; rx_stat_set = '0;
        rd_chk("R13 set wins", 8'd27, 32'h83);

        // R14 counters
        for (int k = 0; k < 3; k++) pulse_inc(4'b0010, '0);
        pulse_inc(4'b0001, '0);
        rd_chk("R14 rx cnt1", 8'd65, 32'd3);
        rd_chk("R14 rx cnt0", 8'd64, 32'd1);
        wr32(8'd96, 32'hFFFF_FFFF);
        rd_chk("R14 cnt write", 8'd96, 32'hFFFF_FFFF);
        pulse_inc('0, 4'b0001);
        rd_chk("R14 wrap to zero", 8'd96, 32'd0);
        rd_chk("R14 wrap event", 8'd35, 32'h1);
        wr32(8'd35, 32'h1);
        rd_chk("R8 event w1c", 8'd35, 32'h0);

        // R10 global clear
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'd32; req_wdata = 32'h1;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk("R10 strobe", 32'(stats_clr), 32'd1);
        @(negedge clk);
        chk("R10 strobe ends", 32'(stats_clr), 32'd0);
        rd_chk("R10 rx cnt1 cleared", 8'd65, 32'd0);
        rd_chk("R10 rx cnt0 cleared", 8'd64, 32'd0);
        rd_chk("R10 bit0 reads 0", 8'd32, 32'd0);

        // R11 timestamp window
        op(1'b1, 8'd50, 32'hFFFF_FFFF, 2'b10, rd, v, e);
        chk("R11 write no error", 32'(e), 32'd0);
        op(1'b0, 8'd50, 32'h0, 2'b10, rd, v, e);
        chk("R11 read data", rd, 32'd0);
        chk("R11 read valid/err", {30'd0, v, e}, 32'h2);

        // R1 size
        op(1'b1, 8'd3, 32'h0, 2'b01, rd, v, e);
        chk("R1 half write err", 32'(e), 32'd1);
        rd_chk("R1 no effect", 8'd3, 32'h1234_5678);
        op(1'b0, 8'd200, 32'h0, 2'b00, rd, v, e);
        chk("R1 byte bad-offset err", {30'd0, v, e}, 32'h1);
        op(1'b0, 8'd3, 32'h0, 2'b11, rd, v, e);
        chk("R1 size 3 err", {30'd0, v, e}, 32'h1);

        // R2 unmapped
        op(1'b0, 8'd10, 32'h0, 2'b10, rd, v, e);
        chk("R2 offset 10", {30'd0, v, e}, 32'h1);
        op(1'b1, 8'd21, 32'h0, 2'b10, rd, v, e);
        chk("R2 offset 21", 32'(e), 32'd1);
        op(1'b0, 8'd38, 32'h0, 2'b10, rd, v, e);
        chk("R2 offset 38", {30'd0, v, e}, 32'h1);
        op(1'b0, 8'd68, 32'h0, 2'b10, rd, v, e);
        chk("R2 offset 68", {30'd0, v, e}, 32'h1);
        op(1'b1, 8'd100, 32'h5, 2'b10, rd, v, e);
        chk("R2 offset 100", 32'(e), 32'd1);

        // R12 latency and pulse width
        op(1'b0, 8'd2, 32'h0, 2'b10, rd, v, e);
        chk("R12 data next cycle", rd, 32'h0000_FFFF);
        chk("R12 valid next cycle", {30'd0, v, e}, 32'h2);
        @(negedge clk);
        chk("R12 valid one cycle", {30'd0, rd_valid, bus_err}, 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule